// File: doc/BRIEF.md
# Authentication Command Sequencer

The sequencer is the policy engine of a challenge/response host authenticator. An upstream parser hands it one checked packet at a time: an opcode, a one-byte first parameter, a two-byte second parameter, the block length that carried it and up to 32 data bytes. The sequencer checks each command's fixed length and its parameter rules. It enforces the order of commands inside one wake session and drives an external hash engine through a start/done pair. It builds the 512-bit message block from the external key, the secret fuse bits and the latched data. It returns a one-byte status for every accepted command.

A session opens with a wake request and closes with a sleep request or when the session watchdog expires. Closing a session drops every in-session permission. Authentication runs in three steps: a first hash over key and challenge, a finishing hash over caller-supplied context, and a single compare of a 32-byte client response against the finished digest. Fuse programming and key personalisation are locked once the disable fuse is burned. A pause command blinds the block for a fixed time.

Top module: `authseq_top`

## Requirements
- R1: After reset the block is asleep (`awake` low). While asleep it never raises `rspValid`, `hashStart`, `readStrobe` or `burnStrobe`, and packets are ignored.
- R2: A wake request while asleep starts a session and `awake` stays high for exactly WDOG_CYC cycles, unless a sleep request ends it earlier. A wake request during a session does not restart the count. Ending a session clears the first-hash, finish and personalisation-ready flags.
- R3: Required total block lengths: first hash (0x08) 39, finish (0x40) 20, compare (0x80) 39, read (0x02) 7, personalise (0x20) 39, burn (0x10) 18, pause (0x00) 7. Any other length returns status 0x0F and nothing is executed.
- R4: Parameter rules: the finish needs param2 = 0. Compare and pause need param1 = 0 and param2 = 0. Personalise needs param1 = 0. Burn needs param2 = 0 and param1 of 0 or 1. A violation returns 0x0F.
- R5: An opcode outside the seven listed returns 0x0F.
- R6: The first hash pulses `hashStart` for one cycle with `hashCont` = 0 and `keySel` = param2. `hashMsg` = {key, challenge}, where the challenge is data bits [255:0]. When param1 = 1, key bits [63:0] are replaced by the 64 secret fuse bits. On `hashDone` the status is 0x00.
- R7: The finish is refused with 0x0F unless a first hash completed in this session. Otherwise `hashCont` = 1 and `hashMsg` = {data[103:0], F, 344 zero bits}. F is the secret fuse bits when param1 bit 5 is set and the disable fuse is burned, and zero otherwise.
- R8: Compare is refused with 0x0F unless a finish completed since the last compare. Otherwise it returns 0x00 when the data equals the finished digest and 0x0F when it does not. Any compare revokes both earlier steps.
- R9: Burn is refused with 0x0F when the disable fuse is burned. With param1 = 0, `burnMap` = data[87:0]. With param1 = 1, `burnMap` = data[87:0] XOR bits [255:168] of the personalisation digest, and the command is refused unless a personalisation completed in this session.
- R10: Personalise is refused with 0x0F when the disable fuse is burned. Otherwise it hashes {key, data} and, on `hashDone`, returns 0x00 and sets the personalisation-ready flag.
- R11: Pause ignores every packet for PAUSE_CYC cycles and then returns 0x00 once.
- R12: Read accepts param1 = 0 with param2[1] = 0 (ROM), or param1 = 1 with param2[1] = 1 (fuses), and param2[15:2] must be 0. It pulses `readStrobe` with `readFuse` = param1[0] and `readAddr` = param2[1:0] and returns 0x00. Any other combination returns 0x0F.
- R13: Suppose a packet is accepted at clock edge k. A non-hash, non-pause result then appears on `rspValid` right after edge k+1, and `hashStart` for a hash command appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeReq | input | 1 | Wake request pulse |
| sleepReq | input | 1 | Sleep request pulse |
| pktValid | input | 1 | Parsed packet present |
| pktLen | input | 6 | Total block length of the packet |
| pktOpcode | input | 8 | Command code |
| pktParam1 | input | 8 | First parameter |
| pktParam2 | input | 16 | Second parameter |
| pktData | input | 256 | Data bytes, first byte in bits [255:248] |
| keySel | output | 16 | Key index for the external key store |
| keyWord | input | 256 | Selected key |
| secretFuse | input | 64 | Secret fuse bits |
| fuseDisable | input | 1 | Disable fuse is burned |
| hashStart | output | 1 | Start the hash engine |
| hashCont | output | 1 | Continue the running digest (second block) |
| hashMsg | output | 512 | Message block for the hash engine |
| hashDone | input | 1 | Hash engine finished |
| hashDigest | input | 256 | Digest from the hash engine |
| rspValid | output | 1 | Status byte valid |
| rspStatus | output | 8 | Status: 0x00 success, 0x0F refused or mismatch |
| readStrobe | output | 1 | Perform a 4-byte read |
| readFuse | output | 1 | Read from fuses (1) or ROM (0) |
| readAddr | output | 2 | Read word address |
| burnStrobe | output | 1 | Program the fuse map |
| burnMap | output | 88 | Fuse map to program |
| awake | output | 1 | Session active |
| busy | output | 1 | A command is in progress |

## Verification
The first set of patterns runs every opcode with correct and off-by-one lengths and with each forbidden parameter value. This separates length faults from parameter faults and from unknown codes. The three-step chain is driven out of order, in order and replayed after a compare. That shows whether each prerequisite flag is set, checked and revoked at the right step. The message block is captured with overwrite on and off, and the finish is run with mode bit 5 under both fuse-disable states, so each operand mux leg is seen on its own. Decrypted and plain burns, pause with a packet arriving mid-window, and watchdog length with a stray second wake round out the timing and lock behaviour.

// File: rtl/authseq_pkg.sv
package authseq_pkg;
  localparam logic [7:0] OP_H0    = 8'h08;
  localparam logic [7:0] OP_H1    = 8'h40;
  localparam logic [7:0] OP_CMP   = 8'h80;
  localparam logic [7:0] OP_READ  = 8'h02;
  localparam logic [7:0] OP_PERS  = 8'h20;
  localparam logic [7:0] OP_BURN  = 8'h10;
  localparam logic [7:0] OP_PAUSE = 8'h00;

  localparam logic [5:0] LEN_H0    = 6'd39;
  localparam logic [5:0] LEN_H1    = 6'd20;
  localparam logic [5:0] LEN_CMP   = 6'd39;
  localparam logic [5:0] LEN_READ  = 6'd7;
  localparam logic [5:0] LEN_PERS  = 6'd39;
  localparam logic [5:0] LEN_BURN  = 6'd18;
  localparam logic [5:0] LEN_PAUSE = 6'd7;

  localparam logic [7:0] ST_OK  = 8'h00;
  localparam logic [7:0] ST_ERR = 8'h0F;

  typedef enum logic [1:0] {MSG_FIRST, MSG_FIN, MSG_PERS} msgSel_t;
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_PAUSE} state_t;

  typedef struct packed {
    logic    latch;
    logic    loadDigest;
    logic    loadPers;
    msgSel_t msgSel;
  } dpCtrl_t;
endpackage

// File: rtl/authseq_dp.sv
module authseq_dp
  import authseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      dpc,
  input  logic [7:0]   p1Q,
  input  logic [255:0] pktData,
  input  logic [255:0] keyWord,
  input  logic [63:0]  secretFuse,
  input  logic         fuseDisable,
  input  logic [255:0] hashDigest,
  output logic [511:0] hashMsg,
  output logic         match,
  output logic [87:0]  burnMap
);
  logic [255:0] dataQ, digestQ, persQ;
  logic [255:0] keyField;
  logic [63:0]  fuseField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      digestQ <= '0;
      persQ   <= '0;
    end else begin
      if (dpc.latch)      dataQ   <= pktData;
      if (dpc.loadDigest) digestQ <= hashDigest;
      if (dpc.loadPers)   persQ   <= hashDigest;
    end
  end

  always_comb begin
    keyField  = (p1Q == 8'd1) ? {keyWord[255:64], secretFuse} : keyWord;
    fuseField = (p1Q[5] && fuseDisable) ? secretFuse : 64'd0;
    case (dpc.msgSel)
      MSG_FIN:  hashMsg = {dataQ[103:0], fuseField, 344'd0};
      MSG_PERS: hashMsg = {keyWord, dataQ};
      default:  hashMsg = {keyField, dataQ};
    endcase
  end

  assign match   = (dataQ == digestQ);
  assign burnMap = (p1Q == 8'd1) ? (dataQ[87:0] ^ persQ[255:168]) : dataQ[87:0];
endmodule

// File: rtl/authseq_ctrl.sv
module authseq_ctrl
  import authseq_pkg::*;
#(
  parameter int unsigned WDOG_CYC  = 400_000_000,
  parameter int unsigned PAUSE_CYC = 2_500_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wakeReq,
  input  logic        sleepReq,
  input  logic        pktValid,
  input  logic [5:0]  pktLen,
  input  logic [7:0]  pktOpcode,
  input  logic [7:0]  pktParam1,
  input  logic [15:0] pktParam2,
  input  logic        fuseDisable,
  input  logic        hashDone,
  input  logic        match,
  output dpCtrl_t     dpc,
  output logic [7:0]  p1Q,
  output logic [15:0] p2Q,
  output logic        hashStart,
  output logic        hashCont,
  output logic        rspValid,
  output logic [7:0]  rspStatus,
  output logic        readStrobe,
  output logic        readFuse,
  output logic [1:0]  readAddr,
  output logic        burnStrobe,
  output logic        awake,
  output logic        busy
);
  localparam int WDW = $clog2(WDOG_CYC + 1);
  localparam int PW  = $clog2(PAUSE_CYC + 1);

  state_t         state;
  logic [WDW-1:0] wdCnt;
  logic [PW-1:0]  pauseCnt;
  logic [5:0]     lenQ;
  logic [7:0]     opQ;
  logic           h0Ok, h1Ok, persRdy;
  logic           wdExp, goSleep, accept, cmdOk;

  assign wdExp   = (wdCnt == WDW'(WDOG_CYC - 1));
  assign goSleep = awake && (sleepReq || wdExp);
  assign accept  = awake && !goSleep && (state == S_IDLE) && pktValid;

  always_comb begin
    case (opQ)
      OP_H0:    cmdOk = (lenQ == LEN_H0);
      OP_H1:    cmdOk = (lenQ == LEN_H1) && (p2Q == 16'd0) && h0Ok;
      OP_CMP:   cmdOk = (lenQ == LEN_CMP) && (p1Q == 8'd0) && (p2Q == 16'd0) && h1Ok;
      OP_READ:  cmdOk = (lenQ == LEN_READ) && (p2Q[15:2] == 14'd0) &&
                        (((p1Q == 8'd0) && !p2Q[1]) || ((p1Q == 8'd1) && p2Q[1]));
      OP_PERS:  cmdOk = (lenQ == LEN_PERS) && (p1Q == 8'd0) && !fuseDisable;
      OP_BURN:  cmdOk = (lenQ == LEN_BURN) && (p2Q == 16'd0) && !fuseDisable &&
                        ((p1Q == 8'd0) || ((p1Q == 8'd1) && persRdy));
      OP_PAUSE: cmdOk = (lenQ == LEN_PAUSE) && (p1Q == 8'd0) && (p2Q == 16'd0);
      default:  cmdOk = 1'b0;
    endcase
  end

  always_comb begin
    dpc.latch      = accept;
    dpc.loadDigest = awake && (state == S_WAIT) && hashDone && (opQ == OP_H1);
    dpc.loadPers   = awake && (state == S_WAIT) && hashDone && (opQ == OP_PERS);
    dpc.msgSel     = (opQ == OP_H1) ? MSG_FIN : (opQ == OP_PERS) ? MSG_PERS : MSG_FIRST;
  end

  assign hashCont = (opQ == OP_H1);
  assign readFuse = p1Q[0];
  assign readAddr = p2Q[1:0];
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; wdCnt <= '0; pauseCnt <= '0;
      lenQ <= '0; opQ <= '0; p1Q <= '0; p2Q <= '0;
      h0Ok <= 1'b0; h1Ok <= 1'b0; persRdy <= 1'b0; awake <= 1'b0;
      rspValid <= 1'b0; rspStatus <= ST_OK; hashStart <= 1'b0;
      readStrobe <= 1'b0; burnStrobe <= 1'b0;
    end else begin
      rspValid   <= 1'b0;
      hashStart  <= 1'b0;
      readStrobe <= 1'b0;
      burnStrobe <= 1'b0;
      if (goSleep) begin
        awake <= 1'b0; state <= S_IDLE;
        h0Ok <= 1'b0; h1Ok <= 1'b0; persRdy <= 1'b0;
      end else if (!awake) begin
        if (wakeReq) begin
          awake <= 1'b1;
          wdCnt <= '0;
        end
      end else begin
        wdCnt <= wdCnt + 1'b1;
        case (state)
          S_IDLE: if (pktValid) begin
            state <= S_EXEC;
            lenQ <= pktLen; opQ <= pktOpcode; p1Q <= pktParam1; p2Q <= pktParam2;
          end
          S_EXEC: begin
            state <= S_IDLE;
            if (!cmdOk) begin
              rspValid <= 1'b1; rspStatus <= ST_ERR;
            end else begin
              case (opQ)
                OP_H0: begin
                  h0Ok <= 1'b0; h1Ok <= 1'b0; hashStart <= 1'b1; state <= S_WAIT;
                end
                OP_H1, OP_PERS: begin
                  hashStart <= 1'b1; state <= S_WAIT;
                end
                OP_CMP: begin
                  rspValid <= 1'b1; rspStatus <= match ? ST_OK : ST_ERR;
                  h0Ok <= 1'b0; h1Ok <= 1'b0;
                end
                OP_READ: begin
                  rspValid <= 1'b1; rspStatus <= ST_OK; readStrobe <= 1'b1;
                end
                OP_BURN: begin
                  rspValid <= 1'b1; rspStatus <= ST_OK; burnStrobe <= 1'b1;
                end
                default: begin
                  state <= S_PAUSE; pauseCnt <= '0;
                end
              endcase
            end
          end
          S_WAIT: if (hashDone) begin
            rspValid <= 1'b1; rspStatus <= ST_OK; state <= S_IDLE;
            if (opQ == OP_H0) h0Ok <= 1'b1;
            if (opQ == OP_H1) h1Ok <= 1'b1;
            if (opQ == OP_PERS) persRdy <= 1'b1;
          end
          default: begin
            if (pauseCnt == PW'(PAUSE_CYC - 1)) begin
              rspValid <= 1'b1; rspStatus <= ST_OK; state <= S_IDLE;
            end else begin
              pauseCnt <= pauseCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> !rspValid && !hashStart && !readStrobe && !burnStrobe); // R1
  AST_WDOG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt < WDW'(WDOG_CYC)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hashStart |=> !hashStart); // R6
  AST_CMP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (awake && state == S_EXEC && opQ == OP_CMP && !h1Ok) |=> (!rspValid || rspStatus == ST_ERR)); // R8
  AST_BURN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    burnStrobe |-> !$past(fuseDisable)); // R9
  AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAUSE) |-> !hashStart && !readStrobe && !burnStrobe); // R11
endmodule

// File: rtl/authseq_top.sv
module authseq_top
  import authseq_pkg::*;
#(
  parameter int unsigned WDOG_CYC  = 400_000_000,
  parameter int unsigned PAUSE_CYC = 2_500_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakeReq,
  input  logic         sleepReq,
  input  logic         pktValid,
  input  logic [5:0]   pktLen,
  input  logic [7:0]   pktOpcode,
  input  logic [7:0]   pktParam1,
  input  logic [15:0]  pktParam2,
  input  logic [255:0] pktData,
  output logic [15:0]  keySel,
  input  logic [255:0] keyWord,
  input  logic [63:0]  secretFuse,
  input  logic         fuseDisable,
  output logic         hashStart,
  output logic         hashCont,
  output logic [511:0] hashMsg,
  input  logic         hashDone,
  input  logic [255:0] hashDigest,
  output logic         rspValid,
  output logic [7:0]   rspStatus,
  output logic         readStrobe,
  output logic         readFuse,
  output logic [1:0]   readAddr,
  output logic         burnStrobe,
  output logic [87:0]  burnMap,
  output logic         awake,
  output logic         busy
);
  dpCtrl_t     dpc;
  logic [7:0]  p1Q;
  logic        match;

  authseq_ctrl #(.WDOG_CYC(WDOG_CYC), .PAUSE_CYC(PAUSE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .sleepReq(sleepReq),
    .pktValid(pktValid), .pktLen(pktLen), .pktOpcode(pktOpcode),
    .pktParam1(pktParam1), .pktParam2(pktParam2), .fuseDisable(fuseDisable),
    .hashDone(hashDone), .match(match), .dpc(dpc), .p1Q(p1Q), .p2Q(keySel),
    .hashStart(hashStart), .hashCont(hashCont), .rspValid(rspValid),
    .rspStatus(rspStatus), .readStrobe(readStrobe), .readFuse(readFuse),
    .readAddr(readAddr), .burnStrobe(burnStrobe), .awake(awake), .busy(busy)
  );

  authseq_dp dp_i (
    .clk(clk), .rstN(rstN), .dpc(dpc), .p1Q(p1Q), .pktData(pktData),
    .keyWord(keyWord), .secretFuse(secretFuse), .fuseDisable(fuseDisable),
    .hashDigest(hashDigest), .hashMsg(hashMsg), .match(match), .burnMap(burnMap)
  );
endmodule

// File: tb/authseq_top_tb_top.sv
module authseq_top_tb_top;
  localparam int unsigned WDOG  = 400;
  localparam int unsigned PAUSE = 20;
  localparam logic [255:0] KEY  = {8{32'h1234_5678}} ^ 256'hF00D;
  localparam logic [255:0] CHAL = {8{32'hC0FF_EE01}} ^ 256'h5A5A_0000_BEEF;
  localparam logic [63:0]  FUSE = 64'hA5A5_3C3C_0F0F_9696;
  localparam logic [87:0]  MAP  = 88'h11_2233_4455_6677_8899_AABB;

  logic clk = 1'b0, rstN = 1'b0;
  logic wakeReq = 0, sleepReq = 0, pktValid = 0, fuseDisable = 0, hashDone = 0;
  logic [5:0] pktLen = '0;
  logic [7:0] pktOpcode = '0, pktParam1 = '0;
  logic [15:0] pktParam2 = '0;
  logic [255:0] pktData = '0;
  logic [15:0] keySel;
  logic hashStart, hashCont, rspValid, readStrobe, readFuse, burnStrobe, awake, busy;
  logic [511:0] hashMsg;
  logic [7:0] rspStatus;
  logic [1:0] readAddr;
  logic [87:0] burnMap;

  always #5 clk = ~clk;

  authseq_top #(.WDOG_CYC(WDOG), .PAUSE_CYC(PAUSE)) dut_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .sleepReq(sleepReq),
    .pktValid(pktValid), .pktLen(pktLen), .pktOpcode(pktOpcode),
    .pktParam1(pktParam1), .pktParam2(pktParam2), .pktData(pktData),
    .keySel(keySel), .keyWord(KEY), .secretFuse(FUSE), .fuseDisable(fuseDisable),
    .hashStart(hashStart), .hashCont(hashCont), .hashMsg(hashMsg),
    .hashDone(hashDone), .hashDigest(CHAL), .rspValid(rspValid),
    .rspStatus(rspStatus), .readStrobe(readStrobe), .readFuse(readFuse),
    .readAddr(readAddr), .burnStrobe(burnStrobe), .burnMap(burnMap),
    .awake(awake), .busy(busy)
  );

  int nChk = 0, nBad = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nBad = nBad + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic gotRsp, sawHash, sawRead, sawBurn, capCont, capRdFuse;
  logic [7:0] capSt;
  logic [511:0] capMsg;
  logic [87:0] capBurn;
  logic [15:0] capKeySel;
  logic [1:0] capRdAddr;
  int lat;

  task automatic runCmd(input logic [5:0] len, input logic [7:0] opc, input logic [7:0] p1,
                        input logic [15:0] p2, input logic [255:0] data, input int maxCyc);
    gotRsp = 0; sawHash = 0; sawRead = 0; sawBurn = 0; lat = 0;
    @(negedge clk);
    pktValid = 1; pktLen = len; pktOpcode = opc; pktParam1 = p1; pktParam2 = p2; pktData = data;
    @(negedge clk);
    pktValid = 0;
    for (int i = 1; i <= maxCyc; i++) begin
      @(negedge clk);
      hashDone = 0;
      if (hashStart) begin
        sawHash = 1; capMsg = hashMsg; capCont = hashCont; capKeySel = keySel;
        hashDone = 1;
      end
      if (rspValid) begin
        gotRsp = 1; capSt = rspStatus; lat = i;
        sawRead = readStrobe; capRdFuse = readFuse; capRdAddr = readAddr;
        sawBurn = burnStrobe; capBurn = burnMap;
        break;
      end
    end
    hashDone = 0;
  endtask

  task automatic wake();
    @(negedge clk); wakeReq = 1;
    @(negedge clk); wakeReq = 0;
  endtask

  task automatic sleep();
    @(negedge clk); sleepReq = 1;
    @(negedge clk); sleepReq = 0;
  endtask

  typedef struct packed {
    logic [5:0] len; logic [7:0] opc; logic [7:0] p1; logic [15:0] p2;
    logic [7:0] st; logic hs;
  } vec_t;

  localparam vec_t VECS [21] = '{
    '{6'd38, 8'h08, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R3 short first hash
    '{6'd20, 8'h40, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R7 finish without first hash
    '{6'd39, 8'h80, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R8 compare without finish
    '{6'd7,  8'h55, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R5 unknown opcode
    '{6'd7,  8'h02, 8'h00, 16'h0000, 8'h00, 1'b0},  // R12 ROM read
    '{6'd7,  8'h02, 8'h00, 16'h0002, 8'h0F, 1'b0},  // R12 ROM read with bit1
    '{6'd7,  8'h02, 8'h01, 16'h0003, 8'h00, 1'b0},  // R12 fuse read
    '{6'd7,  8'h02, 8'h01, 16'h0001, 8'h0F, 1'b0},  // R12 fuse read without bit1
    '{6'd7,  8'h02, 8'h00, 16'h0004, 8'h0F, 1'b0},  // R12 high address bits
    '{6'd7,  8'h02, 8'h02, 16'h0000, 8'h0F, 1'b0},  // R12 bad mode
    '{6'd7,  8'h00, 8'h01, 16'h0000, 8'h0F, 1'b0},  // R4 pause param1
    '{6'd18, 8'h10, 8'h01, 16'h0000, 8'h0F, 1'b0},  // R9 decrypt without personalise
    '{6'd18, 8'h10, 8'h02, 16'h0000, 8'h0F, 1'b0},  // R4 burn mode
    '{6'd17, 8'h10, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R3 short burn
    '{6'd39, 8'h08, 8'h00, 16'h0000, 8'h00, 1'b1},  // R6 first hash
    '{6'd20, 8'h40, 8'h00, 16'h0001, 8'h0F, 1'b0},  // R4 finish param2
    '{6'd20, 8'h40, 8'h00, 16'h0000, 8'h00, 1'b1},  // R7 finish
    '{6'd39, 8'h80, 8'h00, 16'h0000, 8'h00, 1'b0},  // R8 compare match
    '{6'd39, 8'h80, 8'h00, 16'h0000, 8'h0F, 1'b0},  // R8 second compare refused
    '{6'd39, 8'h20, 8'h00, 16'h0000, 8'h00, 1'b1},  // R10 personalise
    '{6'd18, 8'h10, 8'h00, 16'h0000, 8'h00, 1'b0}   // R9 plain burn
  };

  initial begin
    int rspCnt, rspAt, wdLen;
    logic [7:0] pSt;
    logic rdDuringPause;

    repeat (4) @(negedge clk);
    chk("R1 awake after reset", awake, 0);
    chk("R1 rspValid after reset", rspValid, 0);
    rstN = 1;
    runCmd(LEN_READ_T, 8'h02, 8'h00, 16'h0000, CHAL, 10);
    chk("R1 no response while asleep", gotRsp, 0);

    wake();
    chk("R2 awake after wake", awake, 1);
    foreach (VECS[i]) begin
      runCmd(VECS[i].len, VECS[i].opc, VECS[i].p1, VECS[i].p2, CHAL, 40);
      chk($sformatf("R3 R4 vector %0d status", i), {gotRsp, capSt}, {1'b1, VECS[i].st});
      chk($sformatf("R6 R7 vector %0d hash start", i), sawHash, VECS[i].hs);
    end

    runCmd(6'd7, 8'h02, 8'h01, 16'h0003, CHAL, 10);
    chk("R12 read strobe", sawRead, 1);
    chk("R12 read fields", {capRdFuse, capRdAddr}, 3'b111);
    chk("R13 response latency", lat, 1);

    runCmd(6'd39, 8'h08, 8'h01, 16'h0005, CHAL, 40);
    chk("R6 overwrite key half", capMsg[511:256], {KEY[255:64], FUSE});
    chk("R6 challenge half", capMsg[255:0], CHAL);
    chk("R6 key select", capKeySel, 16'h0005);
    chk("R6 first block not continued", capCont, 0);
    chk("R13 hash start latency", lat, 2);
    runCmd(6'd39, 8'h08, 8'h00, 16'h0000, CHAL, 40);
    chk("R6 plain key", capMsg[511:256], KEY);
    runCmd(6'd20, 8'h40, 8'h20, 16'h0000, CHAL, 40);
    chk("R7 continue flag", capCont, 1);
    chk("R7 other info", capMsg[511:408], CHAL[103:0]);
    chk("R7 fuses withheld while unlocked", capMsg[407:344], 64'd0);
    runCmd(6'd39, 8'h80, 8'h00, 16'h0000, ~CHAL, 10);
    chk("R8 compare mismatch", capSt, 8'h0F);
    runCmd(6'd39, 8'h80, 8'h00, 16'h0000, CHAL, 10);
    chk("R8 compare revoked after mismatch", capSt, 8'h0F);

    runCmd(6'd18, 8'h10, 8'h01, 16'h0000, {168'd0, MAP}, 10);
    chk("R9 decrypt burn status", capSt, 8'h00);
    chk("R9 decrypt burn map", capBurn, MAP ^ CHAL[255:168]);
    runCmd(6'd18, 8'h10, 8'h00, 16'h0000, {168'd0, MAP}, 10);
    chk("R9 plain burn map", capBurn, MAP);

    runCmd(6'd39, 8'h08, 8'h00, 16'h0000, CHAL, 40);
    runCmd(6'd20, 8'h40, 8'h00, 16'h0000, CHAL, 40);
    sleep();
    chk("R2 sleep request", awake, 0);
    wake();
    runCmd(6'd39, 8'h80, 8'h00, 16'h0000, CHAL, 10);
    chk("R2 finish flag cleared by sleep", capSt, 8'h0F);
    runCmd(6'd18, 8'h10, 8'h01, 16'h0000, {168'd0, MAP}, 10);
    chk("R2 personalise flag cleared by sleep", capSt, 8'h0F);

    fuseDisable = 1;
    runCmd(6'd18, 8'h10, 8'h00, 16'h0000, {168'd0, MAP}, 10);
    chk("R9 burn locked", {capSt, sawBurn}, {8'h0F, 1'b0});
    runCmd(6'd39, 8'h20, 8'h00, 16'h0000, CHAL, 40);
    chk("R10 personalise locked", {capSt, sawHash}, {8'h0F, 1'b0});
    runCmd(6'd39, 8'h08, 8'h00, 16'h0000, CHAL, 40);
    runCmd(6'd20, 8'h40, 8'h20, 16'h0000, CHAL, 40);
    chk("R7 fuses inserted when locked", capMsg[407:344], FUSE);
    runCmd(6'd20, 8'h40, 8'h00, 16'h0000, CHAL, 40);
    chk("R7 fuses zero without mode bit", capMsg[407:344], 64'd0);
    fuseDisable = 0;

    rspCnt = 0; rspAt = 0; pSt = 8'hEE; rdDuringPause = 0;
    @(negedge clk);
    pktValid = 1; pktLen = 6'd7; pktOpcode = 8'h00; pktParam1 = 0; pktParam2 = 0;
    @(negedge clk);
    pktValid = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      pktValid = (i == 5);
      pktOpcode = 8'h02;
      if (rspValid) begin rspCnt++; rspAt = i; pSt = rspStatus; end
      if (readStrobe) rdDuringPause = 1;
    end
    pktValid = 0;
    chk("R11 single pause response", rspCnt, 1);
    chk("R11 pause length", rspAt, PAUSE + 1);
    chk("R11 pause status", pSt, 8'h00);
    chk("R11 packet ignored in pause", rdDuringPause, 0);
    sleep();

    wake();
    wdLen = 0;
    while (awake && wdLen < 2 * WDOG) begin
      @(negedge clk);
      wdLen++;
      wakeReq = (wdLen == 100);
    end
    wakeReq = 0;
    chk("R2 watchdog length with stray wake", wdLen, WDOG);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  localparam logic [5:0] LEN_READ_T = 6'd7;
endmodule